// File: doc/BRIEF.md
# Segmented Scan Shift Controller

This block drives a group of parallel scan chains in which every chain is cut into the same number of equal-length segments. In shift mode it lets only one segment of each chain move at a time. The flops of all other segments get no clock enable, so they keep their contents. Bypass multiplexing routes each chain's scan input into the active segment and takes the chain's scan output from that same segment. Segment index k is active in every chain at once. Because shift activity is confined to one segment, the switching power during shift drops roughly by the segment count, and the total shift time stays the same.

A start pulse with scan enable high begins one load/unload pass. The segment nearest scan-out (highest index) goes first and the segment nearest scan-in (index 0) goes last. Each segment gets exactly its length in shift cycles, so old response bits leave while new pattern bits enter. One cycle after the final shift, a one-cycle done pulse appears. With scan enable low, every segment enable is asserted and all flops capture the functional data together, so launch-on-capture still works. The scan flops are modelled inside the block as shift registers whose contents are brought out for observation.

Top module: `segscan_ctrl`

## Requirements
- R1: While reset is high, all internal state clears: busy and done are 0, the segment select is 0, and every scan flop holds 0.
- R2: A start pulse while idle with scan enable high makes busy 1 from the next cycle, with the segment select equal to the highest segment index.
- R3: While scan enable is high, at most one segment clock enable is 1 (the active segment during a pass, none while idle). A segment whose enable is 0 keeps its contents unchanged.
- R4: During a pass, the segment select counts down from the highest index to 0. Each segment stays selected for exactly SEG_LEN cycles, so one pass is N_SEGS*SEG_LEN shift cycles.
- R5: During a shift cycle, scan_in[c] enters bit 0 of the active segment of chain c, and each bit moves one place toward bit SEG_LEN-1. scan_out[c] always equals bit SEG_LEN-1 of the segment of chain c named by the segment select. Bit b of segment s of chain c appears on chain_q at index c*N_SEGS*SEG_LEN + s*SEG_LEN + b.
- R6: done is 1 for exactly one cycle. It is 1 in the cycle right after the last shift cycle of segment 0, and busy is 0 in that same cycle.
- R7: With scan enable low, all segment enables are 1, every flop loads its func_d bit (same indexing as chain_q), and any pass in progress is abandoned without a done pulse.
- R8: start has no effect while a pass is running, and it has no effect while scan enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = shift mode, 0 = capture/functional |
| start | input | 1 | Pulse that begins a segment-by-segment pass |
| scan_in | input | N_CHAINS | Serial input, one bit per chain |
| func_d | input | N_CHAINS*N_SEGS*SEG_LEN | Capture data for every flop |
| scan_out | output | N_CHAINS | Serial output from the active segment |
| seg_clk_en | output | N_SEGS | Per-segment clock enable |
| seg_sel | output | clog2(N_SEGS) | Bypass mux select (active segment) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse after a pass completes |
| chain_q | output | N_CHAINS*N_SEGS*SEG_LEN | Observed contents of all scan flops |

## Verification
The bench targets the segment boundary cycles. A counter off by one there would shift a segment SEG_LEN±1 times and misplace every later bit in chain_q. It also covers the end of the pass, where a design that pulses done in the last shift cycle, or holds it for two cycles, disagrees with the model. Dropping scan enable in the middle of a pass checks that the walk is abandoned and everything captures. A controller that kept walking or still emitted done would diverge there. A start pulse during a pass checks that a restarting design does not jump the select back to the top segment. The unload stream is also compared bit by bit, which catches a scan_out mux that reads the wrong segment or the wrong end of it.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    // width of an index able to hold 0..n-1, never below one bit
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/segscan_seq.sv
module segscan_seq
    import segscan_pkg::*;
#(
    parameter int unsigned N_SEGS  = 4,
    parameter int unsigned SEG_LEN = 3,
    localparam int unsigned SEL_W  = idx_bits(N_SEGS),
    localparam int unsigned CNT_W  = idx_bits(SEG_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             start,
    output logic             busy,
    output logic [SEL_W-1:0] seg,
    output logic             done
);
    localparam logic [SEL_W-1:0] TOP_SEG  = SEL_W'(N_SEGS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEG_LEN - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            seg   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!scan_en) begin
                phase <= PH_IDLE;
                seg   <= '0;
                cnt   <= '0;
            end else if (phase == PH_SHIFT) begin
                if (cnt == LAST_CNT) begin
                    cnt <= '0;
                    if (seg == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        seg <= seg - 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                phase <= PH_SHIFT;
                seg   <= TOP_SEG;
                cnt   <= '0;
            end
        end
    end

    assign busy = (phase == PH_SHIFT);

    a_r2_start_loads_top: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && scan_en) |=> (busy && seg == TOP_SEG && cnt == '0));
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (scan_en && busy && cnt == LAST_CNT && seg != '0) |=> (busy && seg == $past(seg) - 1'b1));
    a_r4_hold_within: assert property (@(posedge clk) disable iff (rst)
        (scan_en && busy && cnt != LAST_CNT) |=> (busy && $stable(seg)));
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r7_abort: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (!busy && !done));
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && scan_en && cnt != LAST_CNT) |=> $stable(seg));

endmodule

// File: rtl/segscan_gate.sv
module segscan_gate
    import segscan_pkg::*;
#(
    parameter int unsigned N_SEGS = 4,
    localparam int unsigned SEL_W = idx_bits(N_SEGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              busy,
    input  logic [SEL_W-1:0]  seg,
    output logic [N_SEGS-1:0] seg_clk_en
);
    for (genvar s = 0; s < N_SEGS; s++) begin : g_en
        assign seg_clk_en[s] = !scan_en || (busy && seg == SEL_W'(s));
    end

    a_r3_one_active: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> $onehot0(seg_clk_en));
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !busy) |-> (seg_clk_en == '0));
    a_r7_all_on: assert property (@(posedge clk) disable iff (rst)
        !scan_en |-> (&seg_clk_en));

endmodule

// File: rtl/segscan_chain.sv
module segscan_chain
    import segscan_pkg::*;
#(
    parameter int unsigned N_SEGS  = 4,
    parameter int unsigned SEG_LEN = 3,
    localparam int unsigned SEL_W  = idx_bits(N_SEGS),
    localparam int unsigned BITS   = N_SEGS * SEG_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [N_SEGS-1:0] seg_clk_en,
    input  logic [SEL_W-1:0]  seg,
    input  logic              si,
    input  logic [BITS-1:0]   func_d,
    output logic [BITS-1:0]   q,
    output logic              so
);
    logic [SEG_LEN-1:0] segq [N_SEGS];

    for (genvar s = 0; s < N_SEGS; s++) begin : g_seg
        logic [SEG_LEN-1:0] shifted;
        if (SEG_LEN == 1) begin : g_one
            assign shifted = si;
        end else begin : g_many
            assign shifted = {segq[s][SEG_LEN-2:0], si};
        end

        always_ff @(posedge clk) begin
            if (rst)
                segq[s] <= '0;
            else if (seg_clk_en[s])
                segq[s] <= capture ? func_d[s*SEG_LEN +: SEG_LEN] : shifted;
        end

        assign q[s*SEG_LEN +: SEG_LEN] = segq[s];

        a_r3_gated_holds: assert property (@(posedge clk) disable iff (rst)
            !seg_clk_en[s] |=> $stable(segq[s]));
    end

    assign so = segq[seg][SEG_LEN-1];

endmodule

// File: rtl/segscan_ctrl.sv
module segscan_ctrl
    import segscan_pkg::*;
#(
    parameter int unsigned N_CHAINS = 2,
    parameter int unsigned N_SEGS   = 4,
    parameter int unsigned SEG_LEN  = 3,
    localparam int unsigned SEL_W   = idx_bits(N_SEGS),
    localparam int unsigned CH_BITS = N_SEGS * SEG_LEN,
    localparam int unsigned ALL_BITS = N_CHAINS * CH_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_en,
    input  logic                start,
    input  logic [N_CHAINS-1:0] scan_in,
    input  logic [ALL_BITS-1:0] func_d,
    output logic [N_CHAINS-1:0] scan_out,
    output logic [N_SEGS-1:0]   seg_clk_en,
    output logic [SEL_W-1:0]    seg_sel,
    output logic                busy,
    output logic                done,
    output logic [ALL_BITS-1:0] chain_q
);
    segscan_seq #(.N_SEGS(N_SEGS), .SEG_LEN(SEG_LEN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .scan_en(scan_en),
        .start  (start),
        .busy   (busy),
        .seg    (seg_sel),
        .done   (done)
    );

    segscan_gate #(.N_SEGS(N_SEGS)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .busy      (busy),
        .seg       (seg_sel),
        .seg_clk_en(seg_clk_en)
    );

    for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
        segscan_chain #(.N_SEGS(N_SEGS), .SEG_LEN(SEG_LEN)) u_chain (
            .clk       (clk),
            .rst       (rst),
            .capture   (!scan_en),
            .seg_clk_en(seg_clk_en),
            .seg       (seg_sel),
            .si        (scan_in[c]),
            .func_d    (func_d[c*CH_BITS +: CH_BITS]),
            .q         (chain_q[c*CH_BITS +: CH_BITS]),
            .so        (scan_out[c])
        );
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !done && seg_sel == '0 && chain_q == '0));

endmodule

// File: tb/tb_segscan_ctrl.sv
module tb_segscan_ctrl;
    localparam int C = 2;
    localparam int S = 4;
    localparam int L = 3;
    localparam int NB = C * S * L;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en = 1'b1;
    logic          start = 1'b0;
    logic [C-1:0]  scan_in = '0;
    logic [NB-1:0] func_d = '0;
    logic [C-1:0]  scan_out;
    logic [S-1:0]  seg_clk_en;
    logic [1:0]    seg_sel;
    logic          busy, done;
    logic [NB-1:0] chain_q;

    always #5 clk = ~clk;

    segscan_ctrl #(.N_CHAINS(C), .N_SEGS(S), .SEG_LEN(L)) dut (
        .clk(clk), .rst(rst), .scan_en(scan_en), .start(start),
        .scan_in(scan_in), .func_d(func_d), .scan_out(scan_out),
        .seg_clk_en(seg_clk_en), .seg_sel(seg_sel), .busy(busy),
        .done(done), .chain_q(chain_q)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference
    bit m [C][S][L];
    bit m_busy, m_done;
    int m_seg, m_cnt;
    int shifts_in_pass;

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NB-1:0] m_flat();
        logic [NB-1:0] v;
        for (int c = 0; c < C; c++)
            for (int s = 0; s < S; s++)
                for (int b = 0; b < L; b++)
                    v[c*S*L + s*L + b] = m[c][s][b];
        return v;
    endfunction

    task automatic compare_all();
        logic [S-1:0] en_e;
        logic [C-1:0] so_e;
        for (int s = 0; s < S; s++)
            en_e[s] = !scan_en || (m_busy && m_seg == s);
        for (int c = 0; c < C; c++)
            so_e[c] = m[c][m_seg][L-1];
        cmp("R3/R7 seg_clk_en", 64'(seg_clk_en), 64'(en_e));
        cmp("R4 seg_sel", 64'(seg_sel), 64'(m_seg));
        cmp("R2 busy", 64'(busy), 64'(m_busy));
        cmp("R6 done", 64'(done), 64'(m_done));
        cmp("R5 scan_out", 64'(scan_out), 64'(so_e));
        cmp("R3/R5/R7 chain_q", 64'(chain_q), 64'(m_flat()));
    endtask

    task automatic model_step();
        if (rst) begin
            for (int c = 0; c < C; c++)
                for (int s = 0; s < S; s++)
                    for (int b = 0; b < L; b++) m[c][s][b] = 0;
            m_busy = 0; m_done = 0; m_seg = 0; m_cnt = 0;
            return;
        end
        m_done = 0;
        if (!scan_en) begin
            for (int c = 0; c < C; c++)
                for (int s = 0; s < S; s++)
                    for (int b = 0; b < L; b++) m[c][s][b] = func_d[c*S*L + s*L + b];
            m_busy = 0; m_seg = 0; m_cnt = 0;
        end else if (m_busy) begin
            for (int c = 0; c < C; c++) begin
                for (int b = L - 1; b > 0; b--) m[c][m_seg][b] = m[c][m_seg][b-1];
                m[c][m_seg][0] = scan_in[c];
            end
            shifts_in_pass++;
            if (m_cnt == L - 1) begin
                m_cnt = 0;
                if (m_seg == 0) begin m_busy = 0; m_done = 1; end
                else m_seg--;
            end else m_cnt++;
        end else if (start) begin
            m_busy = 1; m_seg = S - 1; m_cnt = 0; shifts_in_pass = 0;
        end
    endtask

    task automatic cyc(bit r, bit se, bit st, logic [C-1:0] si, logic [NB-1:0] fd);
        @(negedge clk);
        rst = r; scan_en = se; start = st; scan_in = si; func_d = fd;
        #1 compare_all();
        model_step();
    endtask

    task automatic run_pass(bit check_len);
        int n;
        cyc(0, 1, 1, C'($urandom), NB'(0));
        n = 0;
        while (m_busy && n < 100) begin
            cyc(0, 1, (n == 4), C'($urandom), NB'(0)); // R8: start mid-pass ignored
            n++;
        end
        if (check_len) cmp("R4 pass length", 64'(shifts_in_pass), 64'(S * L));
        cyc(0, 1, 0, '0, '0);   // done cycle observed here (R6)
        cyc(0, 1, 0, '0, '0);   // R6: done gone again
    endtask

    initial begin
        repeat (2) @(posedge clk);
        m_busy = 0; m_done = 0; m_seg = 0; m_cnt = 0; shifts_in_pass = 0;
        for (int c = 0; c < C; c++)
            for (int s = 0; s < S; s++)
                for (int b = 0; b < L; b++) m[c][s][b] = 0;
        // R1: reset state
        cyc(1, 1, 0, '0, '0);
        cyc(1, 1, 0, '0, '0);
        cyc(0, 1, 0, '0, '0);
        // R3: idle in shift mode, nothing moves
        repeat (3) cyc(0, 1, 0, 2'b11, '0);
        // R2/R4/R5/R6: first load
        run_pass(1);
        // R7: capture a pattern
        cyc(0, 0, 0, '0, {$urandom, $urandom});
        // R5: unload captured response while loading next pattern
        run_pass(1);
        // R8: start with scan enable low ignored
        cyc(0, 0, 1, '0, {$urandom, $urandom});
        cyc(0, 1, 0, '0, '0);
        // R7: abort mid-pass
        cyc(0, 1, 1, 2'b01, '0);
        repeat (5) cyc(0, 1, 0, C'($urandom), '0);
        cyc(0, 0, 0, '0, {$urandom, $urandom});
        repeat (3) cyc(0, 1, 0, 2'b10, '0);
        // another full pass after abort
        run_pass(1);
        // R1: reset in the middle of a pass
        cyc(0, 1, 1, '0, '0);
        repeat (3) cyc(0, 1, 0, 2'b11, '0);
        cyc(1, 1, 0, '0, '0);
        cyc(0, 1, 0, '0, '0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule